// File: doc/BRIEF.md
# GPIO controller with change interrupts

The block is a register-mapped general-purpose I/O controller for up to 32 lines. Software sets the direction of each line, writes the value driven on the output lines and reads back the level of every line. Input levels pass through a two-stage synchroniser. A both-edge detector then records every transition of an input line in a sticky per-line change register. Software acknowledges a change by writing a one to its bit.

A separate enable register selects which change bits may raise the interrupt. The single interrupt output is high whenever at least one line has both its change bit and its enable bit set. A write-mask register restricts which bits a data write may update, so software can change a subset of outputs without a read-modify-write sequence. A read-only type register returns a fixed code that identifies the detector as both-edge only. The number of implemented lines is a parameter. Unimplemented bit positions read as zero.

The register port is a simple single-cycle strobe interface with a word index, so byte offset = 4 × index. Write data is captured on the rising clock edge while `bus_req` and `bus_wr` are high. Read data is combinational from the index.

Top module: `gpio_chg_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the registers hold these values: all lines are inputs (`pin_oe` = 0), `pin_out` = 0, the enable and change registers read 0, the write mask reads all ones for the implemented lines, and `irq` = 0.
- R2: The direction register is at byte offset 0x00 (index 0). A bit value of 1 makes that line an output (`pin_oe` bit high), and 0 makes it an input. The register reads back as written.
- R3: The data register is at byte offset 0x04 (index 1). A write sets the value on `pin_out`. A read returns the driven value for output lines and the synchronised pin level for input lines.
- R4: The write mask is at byte offset 0x10 (index 4). A data write updates only the bits whose mask bit is 1.
- R5: A rising or a falling transition on an input line sets that line's bit in the change register (byte offset 0x0C, index 3). The bit is visible after the third rising clock edge following the pin change, and is not visible after the second. Transitions on output lines set nothing.
- R6: Writing 1 to a change bit clears it. Writing 0 leaves it unchanged.
- R7: If an edge sets a change bit in the same cycle that a write clears it, the bit ends at 1.
- R8: The interrupt enable register is at byte offset 0x08 (index 2). `irq` is the OR over all lines of (change bit AND enable bit).
- R9: The type register at byte offset 0x14 (index 5) always reads 0x00000003 (both-edge). Writes to it have no effect.
- R10: Bits at or above NUM_LINES read 0 in every register. Indices 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_widx | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_widx` (combinational) |
| pin_in | input | NUM_LINES | Asynchronous line levels from the pads |
| pin_out | output | NUM_LINES | Output values to the pads |
| pin_oe | output | NUM_LINES | Output enables (1 = drive) |
| irq | output | 1 | Combined change interrupt |

## Verification
Two functions can act on the same change bit in one cycle: a detected edge setting it, and a software write clearing it. The bench provokes this by toggling an input pin on a falling clock edge and timing a write-one-to-clear so that its capturing edge is the third rising edge after the toggle, which is the edge where the synchronised transition is latched. The result is judged by reading the change register and `irq` afterwards: the bit must still be 1. Outside that directed case, random pin toggles and random clears are kept in separate cycles, so that the bench's model of the change register stays exact.

// File: rtl/gpio_chg_pkg.sv
// Package: shared register indices and constants for the GPIO change controller.
// Assumes a 32-bit data bus and a word-indexed register port.
package gpio_chg_pkg;
    localparam int BUS_W  = 32;
    localparam int IDX_W  = 3;

    localparam logic [IDX_W-1:0] IDX_DIR  = 3'd0;
    localparam logic [IDX_W-1:0] IDX_DATA = 3'd1;
    localparam logic [IDX_W-1:0] IDX_IEN  = 3'd2;
    localparam logic [IDX_W-1:0] IDX_CHG  = 3'd3;
    localparam logic [IDX_W-1:0] IDX_MASK = 3'd4;
    localparam logic [IDX_W-1:0] IDX_TYPE = 3'd5;

    localparam logic [BUS_W-1:0] TYPE_BOTH_EDGE = 32'h0000_0003;
endpackage

// File: rtl/gpio_chg_sync.sv
// Module: per-line multi-stage synchroniser for asynchronous pad inputs.
// Assumes each bit is an independent signal, so no bus coherency is implied.
module gpio_chg_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the level one flop further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_chg_detect.sv
// Module: both-edge detector and sticky change register with write-one-to-clear.
// Assumes 'level' is already synchronous. Only input-direction lines
// (dir bit 0) can set a bit. A set in the same cycle as a clear wins.
module gpio_chg_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] dir,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] chg_q
);
    logic [W-1:0] prev_q;
    logic [W-1:0] edge_vec;

    // Edge on any input-direction line, in either direction.
    always_comb edge_vec = (level ^ prev_q) & ~dir;

    // Remember the previous synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    // Sticky change bits: clear on write-one, set on edge, set dominates.
    always_ff @(posedge clk) begin
        if (!rst_n) chg_q <= '0;
        else        chg_q <= (chg_q & ~(clr_en ? clr_mask : '0)) | edge_vec;
    end

    // R5
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_vec) |=> ((chg_q & $past(edge_vec)) == $past(edge_vec)));

    // R5
    outdir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((chg_q & ~$past(chg_q) & $past(dir)) == '0));

    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((chg_q & $past(clr_mask & ~edge_vec)) == '0));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en && edge_vec == '0) |=> $stable(chg_q));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && ((clr_mask & edge_vec) != '0)) |=>
            ((chg_q & $past(clr_mask & edge_vec)) == $past(clr_mask & edge_vec)));
endmodule

// File: rtl/gpio_chg_ctrl.sv
// Module: top of the GPIO controller with change interrupts.
// Holds direction, data, enable and mask registers, decodes the word-indexed
// register port, and ORs enabled change bits into one interrupt.
// Assumes single-cycle write strobes and pins held stable across reset.
module gpio_chg_ctrl
    import gpio_chg_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_wr,
    input  logic [IDX_W-1:0]     bus_widx,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe,
    output logic                 irq
);
    localparam int N = NUM_LINES;

    logic [N-1:0] dir_q, dat_q, ien_q, mask_q, chg_q, lvl_sync;
    logic [N-1:0] wd;
    logic         wr_dir, wr_dat, wr_ien, wr_mask, wr_chg;

    assign wd      = bus_wdata[N-1:0];
    assign wr_dir  = bus_req && bus_wr && (bus_widx == IDX_DIR);
    assign wr_dat  = bus_req && bus_wr && (bus_widx == IDX_DATA);
    assign wr_ien  = bus_req && bus_wr && (bus_widx == IDX_IEN);
    assign wr_chg  = bus_req && bus_wr && (bus_widx == IDX_CHG);
    assign wr_mask = bus_req && bus_wr && (bus_widx == IDX_MASK);

    gpio_chg_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (lvl_sync)
    );

    gpio_chg_detect #(.W(N)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (lvl_sync),
        .dir      (dir_q),
        .clr_en   (wr_chg),
        .clr_mask (wd),
        .chg_q    (chg_q)
    );

    // Control registers: direction, enable and write mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            ien_q  <= '0;
            mask_q <= '1;
        end else begin
            if (wr_dir)  dir_q  <= wd;
            if (wr_ien)  ien_q  <= wd;
            if (wr_mask) mask_q <= wd;
        end
    end

    // Output data register: only mask-enabled bits take the write.
    always_ff @(posedge clk) begin
        if (!rst_n)      dat_q <= '0;
        else if (wr_dat) dat_q <= (dat_q & ~mask_q) | (wd & mask_q);
    end

    // Read mux with zero extension of the implemented lines.
    always_comb begin
        bus_rdata = '0;
        case (bus_widx)
            IDX_DIR:  bus_rdata[N-1:0] = dir_q;
            IDX_DATA: bus_rdata[N-1:0] = (dat_q & dir_q) | (lvl_sync & ~dir_q);
            IDX_IEN:  bus_rdata[N-1:0] = ien_q;
            IDX_CHG:  bus_rdata[N-1:0] = chg_q;
            IDX_MASK: bus_rdata[N-1:0] = mask_q;
            IDX_TYPE: bus_rdata        = TYPE_BOTH_EDGE;
            default:  bus_rdata        = '0;
        endcase
    end

    assign pin_out = dat_q;
    assign pin_oe  = dir_q;
    assign irq     = |(chg_q & ien_q);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq));

    // R4
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dat |=> ((pin_out & ~$past(mask_q)) == ($past(pin_out) & ~$past(mask_q))));

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);
endmodule

// File: tb/sim_gpio_chg_ctrl.sv
// Bench: directed corner cases plus seeded random register and pin activity,
// checked against a bench-side model of the registers.
module sim_gpio_chg_ctrl;
    localparam int NL = 24;
    localparam logic [31:0] LM = 32'h00FF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_req, bus_wr;
    logic [2:0]    bus_widx;
    logic [31:0]   bus_wdata, bus_rdata;
    logic [NL-1:0] pin_in, pin_out, pin_oe;
    logic          irq;

    int total = 0;
    int bad   = 0;

    logic [31:0] m_dir, m_dat, m_ien, m_chg, m_mask, m_pin;

    always #10 clk = ~clk;

    gpio_chg_ctrl #(.NUM_LINES(NL)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input int idx);
        case (idx)
            0: return m_dir;
            1: return ((m_dat & m_dir) | (m_pin & ~m_dir)) & LM;
            2: return m_ien;
            3: return m_chg;
            4: return m_mask;
            5: return 32'h3;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return |(m_chg & m_ien);
    endfunction

    // Write at the next rising edge, return at the following falling edge.
    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_widx = 3'(idx); bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        bus_widx = 3'(idx);
        #1;
        d = bus_rdata;
    endtask

    // Apply write to the model.
    task automatic mwr(input int idx, input logic [31:0] d);
        wr(idx, d);
        case (idx)
            0: m_dir  = d & LM;
            1: m_dat  = ((m_dat & ~m_mask) | (d & m_mask)) & LM;
            2: m_ien  = d & LM;
            3: m_chg  = m_chg & ~d & LM;
            4: m_mask = d & LM;
            default: ;
        endcase
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        m_chg = m_chg | ((v ^ m_pin) & ~m_dir & LM);
        m_pin = v & LM;
        pin_in = v[NL-1:0];
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] r;
        for (int i = 0; i < 8; i++) begin
            rd(i, r);
            chk($sformatf("%s reg%0d (R2 R3 R4 R6 R8 R9 R10)", tag, i), r, exp_rd(i));
        end
        chk({tag, " pin_out R3"}, 32'(pin_out), m_dat);
        chk({tag, " pin_oe R2"}, 32'(pin_oe), m_dir);
        chk({tag, " irq R8"}, 32'(irq), 32'(exp_irq()));
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd4711));
        bus_req = 0; bus_wr = 0; bus_widx = 0; bus_wdata = 0; pin_in = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_dir = 0; m_dat = 0; m_ien = 0; m_chg = 0; m_mask = LM; m_pin = 0;

        // R1 reset state
        rd(4, r); chk("R1 mask reset", r, LM);
        rd(3, r); chk("R1 change reset", r, 0);
        chk("R1 irq reset", 32'(irq), 0);
        chk("R1 pin_oe reset", 32'(pin_oe), 0);
        check_all("R1");

        // R5 timing of a rising edge on line 0
        @(negedge clk);
        pin_in[0] = 1'b1; m_pin[0] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd(3, r); chk("R5 not yet after 2 edges", r, 0);
        @(posedge clk);
        @(negedge clk);
        rd(3, r); chk("R5 set after 3rd edge", r, 32'h1);
        m_chg[0] = 1'b1;
        mwr(3, 32'h1); rd(3, r); chk("R6 clear by one", r, 0);
        // falling edge
        set_pins(32'h0); rd(3, r); chk("R5 falling edge", r, 32'h1);
        mwr(3, 32'h0); rd(3, r); chk("R6 zero write keeps", r, 32'h1);
        mwr(2, 32'h1); chk("R8 irq enabled", 32'(irq), 1);
        mwr(3, 32'h1); chk("R8 irq after clear", 32'(irq), 0);

        // R5 output lines ignore pin transitions
        mwr(0, 32'h0000_0002);
        set_pins(32'h0000_0002); rd(3, r); chk("R5 output line no change", r, 0);
        mwr(0, 32'h0);
        set_pins(32'h0);
        mwr(3, LM);

        // R7 edge and clear in the same cycle
        @(negedge clk);
        pin_in[4] = 1'b1; m_pin[4] = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        bus_req = 1; bus_wr = 1; bus_widx = 3'd3; bus_wdata = 32'h10;
        @(posedge clk); @(negedge clk);
        bus_req = 0; bus_wr = 0;
        rd(3, r); chk("R7 set wins over clear", r, 32'h10);
        m_chg = 32'h10;
        mwr(3, 32'h10);

        // R4 write mask
        mwr(4, 32'h0000_00F0);
        mwr(0, LM);
        mwr(1, 32'hFFFF_FFFF);
        chk("R4 masked data write", 32'(pin_out), 32'h0000_00F0);
        mwr(4, LM);

        // R9 type register is read-only
        mwr(5, 32'h0);
        rd(5, r); chk("R9 type code", r, 32'h3);
        // R10 upper bits and unused indices
        mwr(2, 32'hFFFF_FFFF);
        rd(2, r); chk("R10 upper bits zero", r, LM);
        rd(6, r); chk("R10 index 6 zero", r, 0);
        mwr(2, 32'h0);
        check_all("directed");

        // Random phase
        for (int it = 0; it < 300; it++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0: mwr(0, $urandom);
                1: mwr(1, $urandom);
                2: mwr(2, $urandom);
                3: mwr(3, $urandom);
                4: mwr(4, $urandom);
                default: set_pins($urandom);
            endcase
            check_all($sformatf("rand%0d", it));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule